// File: doc/BRIEF.md
# Interleaved Shared SRAM Arbiter

This block lets a display refresh reader and a processor share one single-port asynchronous SRAM without either side waiting on the other. It divides the 50 MHz system clock into 20 ns access slots that strictly alternate between the two requesters. The video side therefore gets one read every 40 ns, which matches a 25 MHz pixel fetch rate. The processor gets a fixed, predictable share of the bandwidth no matter where the beam is in the line or frame. The frame buffer sits in the low part of the SRAM, and the video address input is only as wide as that region. Processor code and data sit above it, but the processor may read or write anywhere, including the frame buffer.

Every SRAM pin (address, output enable, write enable and the driven data) comes from a register. A read is captured at the end of its slot, and a one-cycle strobe is sent back to the side that owns the slot. The processor issues single-cycle requests. A request that lands on a video slot waits in a one-entry holding register and goes out in the following slot.

When the reclaim enable is set and the video side reports blanking, the video slots are handed to the processor, so every slot can serve it.

Top module: `shram_slot_arbiter`

## Requirements
- R1: While reset is applied, `sram_oe_n` and `sram_we_n` are 1 and `vid_valid` and `cpu_ack` are 0.
- R2: After reset the slots alternate on every clock edge, and the first slot is a video slot. Without reclaim, a video read is issued every second edge, so `vid_valid` is high on every other cycle and never on two cycles in a row.
- R3: In a video slot, `vid_addr` is sampled at the edge that opens the slot and appears on `sram_addr` with its upper `ADDR_W-VID_AW` bits zero. One edge later `vid_rdata` holds the SRAM word at that address, and `vid_valid` is high for one cycle.
- R4: A processor read (`cpu_we`=0) returns the SRAM word in `cpu_rdata`, which is valid while `cpu_ack` is high. `cpu_ack` is high for exactly one cycle for each request.
- R5: On a processor write (`cpu_we`=1), the block drives `cpu_wdata` onto `sram_dq` at `cpu_addr` only while `sram_we_n` is 0, and it then pulses `cpu_ack`. A write into the frame-buffer region is returned by later video reads.
- R6: `cpu_ack` rises 1 cycle after the edge that samples `cpu_req` if that edge opens a processor-owned slot. It rises 2 cycles after if that edge opens a video slot, because the request is held for the next slot. It never takes longer than 2 cycles.
- R7: Processor traffic never removes or delays a video read: the alternating `vid_valid` pattern and its data are the same under processor load.
- R8: While `reclaim_en`=1 and `vid_blank`=1, no video read is issued (`vid_valid` stays 0 from the second cycle on), and every processor request is acknowledged 1 cycle after its sampling edge.
- R9: While `reclaim_en`=0, `vid_blank` has no effect, and video reads continue in alternate slots.
- R10: `sram_oe_n` and `sram_we_n` are never both 0. The block drives `sram_dq` only during processor write slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one access slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reclaim_en | input | 1 | Gives video slots to the processor during blanking |
| vid_blank | input | 1 | Video side is in horizontal or vertical blanking |
| vid_addr | input | VID_AW | Frame-buffer word address of the next video read |
| vid_rdata | output | DATA_W | Captured video read data |
| vid_valid | output | 1 | One-cycle strobe, `vid_rdata` is new |
| cpu_req | input | 1 | One-cycle processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion strobe |
| sram_addr | output | ADDR_W | SRAM address pins |
| sram_dq | inout | DATA_W | SRAM data pins |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
A video address driven before an edge gives its data and `vid_valid` one edge later. The bench changes inputs on falling edges and keeps the video addresses of the last two falling edges, so each strobe is checked against the address that was sampled for it. A processor request presented before edge E must be acknowledged after E+1 or E+2. The bench counts falling edges after dropping the request, accepts only a count of 1 or 2, and requires 1 under reclaim. It offsets requests by zero to three idle cycles so that both latencies occur. The pin-level checks sample `sram_we_n`, `sram_addr` and `sram_dq` in the middle of each slot. At that point the registered pins of the slot launched at the preceding edge are settled.

// File: rtl/shram_pkg.sv
`timescale 1ns/1ps
package shram_pkg;

  typedef enum logic {
    OWN_VID = 1'b0,
    OWN_CPU = 1'b1
  } slot_own_e;

  typedef struct packed {
    logic      vld;
    slot_own_e own;
    logic      we;
  } acc_ctl_t;

endpackage

// File: rtl/shram_slot_seq.sv
`timescale 1ns/1ps
module shram_slot_seq
  import shram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reclaim_en,
  input  logic vid_blank,
  output logic grant_vid,
  output logic grant_cpu
);

  slot_own_e phase_q;
  slot_own_e phase_d;
  logic      reclaim;

  always_comb begin
    phase_d   = (phase_q == OWN_VID) ? OWN_CPU : OWN_VID;
    reclaim   = reclaim_en & vid_blank;
    grant_vid = (phase_q == OWN_VID) && !reclaim;
    grant_cpu = !grant_vid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= OWN_VID;
    end else begin
      phase_q <= phase_d;
    end
  end

  AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == OWN_VID) |=> (phase_q == OWN_CPU)); // R2
  AST_CPU_AFTER_VID: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vid |=> grant_cpu); // R7

endmodule

// File: rtl/shram_cpu_hold.sv
`timescale 1ns/1ps
module shram_cpu_hold #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              grant_cpu,
  output logic              go,
  output logic              go_we,
  output logic [ADDR_W-1:0] go_addr,
  output logic [DATA_W-1:0] go_wdata
);

  logic              pend_q;
  logic              pend_d;
  logic              pend_ld;
  logic              pend_we_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;

  always_comb begin
    pend_ld = cpu_req && !grant_cpu;
    pend_d  = pend_q;
    if (grant_cpu) begin
      pend_d = 1'b0;
    end
    if (pend_ld) begin
      pend_d = 1'b1;
    end
    go       = grant_cpu && (pend_q || cpu_req);
    go_we    = pend_q ? pend_we_q    : cpu_we;
    go_addr  = pend_q ? pend_addr_q  : cpu_addr;
    go_wdata = pend_q ? pend_wdata_q : cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_ld) begin
      pend_we_q    <= cpu_we;
      pend_addr_q  <= cpu_addr;
      pend_wdata_q <= cpu_wdata;
    end
  end

  AST_HOLD_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q); // R6

endmodule

// File: rtl/shram_launch.sv
`timescale 1ns/1ps
module shram_launch
  import shram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int VID_AW = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_vid,
  input  logic [VID_AW-1:0] vid_addr,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  inout  wire  [DATA_W-1:0] sram_dq,
  output acc_ctl_t          acc_o
);

  localparam int HI_W = ADDR_W - VID_AW;

  acc_ctl_t          acc_q;
  acc_ctl_t          acc_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_q;
  logic              wdata_ld;
  logic              oe_n_q;
  logic              oe_n_d;
  logic              we_n_q;
  logic              we_n_d;
  logic              drive_q;

  always_comb begin
    acc_d.vld = grant_vid || go;
    acc_d.own = grant_vid ? OWN_VID : OWN_CPU;
    acc_d.we  = !grant_vid && go && go_we;
    addr_d    = grant_vid ? {{HI_W{1'b0}}, vid_addr} : go_addr;
    wdata_ld  = !grant_vid && go && go_we;
    oe_n_d    = !(acc_d.vld && !acc_d.we);
    we_n_d    = !(acc_d.vld && acc_d.we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '{vld: 1'b0, own: OWN_VID, we: 1'b0};
      addr_q  <= '0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      drive_q <= acc_d.we;
      if (acc_d.vld) begin
        addr_q <= addr_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wdata_ld) begin
      wdata_q <= go_wdata;
    end
  end

  assign sram_addr = addr_q;
  assign sram_oe_n = oe_n_q;
  assign sram_we_n = we_n_q;
  assign sram_dq   = drive_q ? wdata_q : {DATA_W{1'bz}};
  assign acc_o     = acc_q;

  AST_DRIVE_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (acc_q.own == OWN_CPU && !sram_we_n)); // R10
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n)); // R10
  AST_VID_LOW_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q.vld && acc_q.own == OWN_VID) |-> (sram_addr[ADDR_W-1:VID_AW] == '0)); // R3

endmodule

// File: rtl/shram_rd_capture.sv
`timescale 1ns/1ps
module shram_rd_capture
  import shram_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_ctl_t          acc_i,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              vid_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack
);

  logic vid_cap;
  logic cpu_cap;
  logic cpu_done;
  logic vid_valid_q;
  logic cpu_ack_q;
  logic [DATA_W-1:0] vid_rdata_q;
  logic [DATA_W-1:0] cpu_rdata_q;

  always_comb begin
    vid_cap  = acc_i.vld && (acc_i.own == OWN_VID) && !acc_i.we;
    cpu_done = acc_i.vld && (acc_i.own == OWN_CPU);
    cpu_cap  = cpu_done && !acc_i.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_valid_q <= 1'b0;
      cpu_ack_q   <= 1'b0;
    end else begin
      vid_valid_q <= vid_cap;
      cpu_ack_q   <= cpu_done;
    end
  end

  always_ff @(posedge clk) begin
    if (vid_cap) begin
      vid_rdata_q <= rd_data;
    end
    if (cpu_cap) begin
      cpu_rdata_q <= rd_data;
    end
  end

  assign vid_valid = vid_valid_q;
  assign vid_rdata = vid_rdata_q;
  assign cpu_ack   = cpu_ack_q;
  assign cpu_rdata = cpu_rdata_q;

  AST_CPU_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i.vld && acc_i.own == OWN_CPU) |=> cpu_ack); // R4

endmodule

// File: rtl/shram_slot_arbiter.sv
`timescale 1ns/1ps
module shram_slot_arbiter
  import shram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int VID_AW = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reclaim_en,
  input  logic              vid_blank,
  input  logic [VID_AW-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              vid_valid,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq,
  output logic              sram_oe_n,
  output logic              sram_we_n
);

  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic              grant_vid;
  logic              grant_cpu;
  logic              go;
  logic              go_we;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_wdata;
  acc_ctl_t          acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sn = rst_pipe[1];

  shram_slot_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .reclaim_en (reclaim_en),
    .vid_blank  (vid_blank),
    .grant_vid  (grant_vid),
    .grant_cpu  (grant_cpu)
  );

  shram_cpu_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_hold (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .grant_cpu (grant_cpu),
    .go        (go),
    .go_we     (go_we),
    .go_addr   (go_addr),
    .go_wdata  (go_wdata)
  );

  shram_launch #(
    .ADDR_W (ADDR_W),
    .VID_AW (VID_AW),
    .DATA_W (DATA_W)
  ) i_launch (
    .clk       (clk),
    .rst_n     (rst_sn),
    .grant_vid (grant_vid),
    .vid_addr  (vid_addr),
    .go        (go),
    .go_we     (go_we),
    .go_addr   (go_addr),
    .go_wdata  (go_wdata),
    .sram_addr (sram_addr),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_dq   (sram_dq),
    .acc_o     (acc)
  );

  shram_rd_capture #(
    .DATA_W (DATA_W)
  ) i_capture (
    .clk       (clk),
    .rst_n     (rst_sn),
    .acc_i     (acc),
    .rd_data   (sram_dq),
    .vid_rdata (vid_rdata),
    .vid_valid (vid_valid),
    .cpu_rdata (cpu_rdata),
    .cpu_ack   (cpu_ack)
  );

  AST_VID_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_sn)
    vid_valid |=> !vid_valid); // R2
  AST_RECLAIM_NO_VID: assert property (@(posedge clk) disable iff (!rst_sn)
    (reclaim_en && vid_blank) |-> ##2 !vid_valid); // R8

endmodule

// File: tb/test_shram_slot_arbiter.sv
`timescale 1ns/1ps
module test_shram_slot_arbiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reclaim_en;
  logic        vid_blank;
  logic [8:0]  vid_addr;
  logic [15:0] vid_rdata;
  logic        vid_valid;
  logic        cpu_req;
  logic        cpu_we;
  logic [9:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        cpu_ack;
  logic [9:0]  sram_addr;
  wire  [15:0] sram_dq;
  logic        sram_oe_n;
  logic        sram_we_n;

  logic [15:0] mem     [1024];
  logic [15:0] ref_mem [1024];

  int  n_chk = 0;
  int  n_bad = 0;
  bit  seen1 = 0;
  bit  seen2 = 0;

  always #10 clk = ~clk;

  shram_slot_arbiter i_shram_slot_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .reclaim_en (reclaim_en),
    .vid_blank  (vid_blank),
    .vid_addr   (vid_addr),
    .vid_rdata  (vid_rdata),
    .vid_valid  (vid_valid),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .cpu_ack    (cpu_ack),
    .sram_addr  (sram_addr),
    .sram_dq    (sram_dq),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 59) + 16'h01C5);
  endfunction

  // behavioural asynchronous SRAM
  assign sram_dq = (!sram_oe_n && sram_we_n) ? mem[sram_addr] : 16'hzzzz;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (!sram_we_n) begin
      mem[sram_addr] <= sram_dq;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // R10 pin monitor, mid-slot
  always @(negedge clk) begin
    if (rst_n) chk(!(!sram_oe_n && !sram_we_n), "R10 oe/we overlap", {sram_oe_n, sram_we_n}, 2'b11);
  end

  task automatic t_vid_stream(input int n, input int base, input int step, input string rq,
                              input bit expect_reads, input bit chk_addr);
    int nv = 0;
    logic pv = 1'b0;
    logic [8:0] h1 = vid_addr;
    logic [8:0] h2 = vid_addr;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (expect_reads) begin
        if (k > 0) chk(vid_valid != pv, {rq, " alternation"}, vid_valid, !pv);
        if (vid_valid) begin
          nv++;
          chk(vid_rdata == ref_mem[h2], {rq, " video data"}, vid_rdata, ref_mem[h2]);
        end
        if (chk_addr && !sram_oe_n)
          chk(sram_addr == {1'b0, h1}, {rq, " video address low region"}, sram_addr, {1'b0, h1});
      end else begin
        chk(!vid_valid, {rq, " no video read"}, vid_valid, 0);
      end
      pv = vid_valid;
      h2 = h1;
      h1 = 9'((base + k * step) % 512);
      vid_addr = h1;
    end
    if (expect_reads) chk(nv == n / 2, {rq, " video read count"}, nv, n / 2);
  endtask

  task automatic cpu_access(input bit we, input logic [9:0] a, input logic [15:0] wd,
                            output logic [15:0] rd, output int lat);
    bit got = 0;
    bit drv = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (!sram_we_n) begin
      drv = 1;
      chk(sram_addr == a && sram_dq == wd, "R5 write pins", sram_dq, wd);
    end
    lat = 0;
    for (int k = 1; k <= 4 && !got; k++) begin
      @(negedge clk);
      if (!sram_we_n) begin
        drv = 1;
        chk(sram_addr == a && sram_dq == wd, "R5 write pins", sram_dq, wd);
      end
      if (cpu_ack) begin
        got = 1;
        lat = k;
      end
    end
    chk(got && lat <= 2, "R6 ack latency", lat, 2);
    if (lat == 1) seen1 = 1;
    if (lat == 2) seen2 = 1;
    rd = cpu_rdata;
    if (we) begin
      chk(drv, "R5 write strobe seen", drv, 1);
      ref_mem[a] = wd;
    end else begin
      chk(cpu_rdata == ref_mem[a], "R4 read data", cpu_rdata, ref_mem[a]);
    end
    @(negedge clk);
    chk(!cpu_ack, "R4 ack one cycle", cpu_ack, 0);
  endtask

  task automatic t_reset();
    bit found = 0;
    rst_n = 1'b0; reclaim_en = 1'b0; vid_blank = 1'b0; vid_addr = 9'd0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < 1024; i++) ref_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    chk(sram_oe_n, "R1 oe_n in reset", sram_oe_n, 1);
    chk(sram_we_n, "R1 we_n in reset", sram_we_n, 1);
    chk(!vid_valid, "R1 vid_valid in reset", vid_valid, 0);
    chk(!cpu_ack, "R1 cpu_ack in reset", cpu_ack, 0);
    vid_addr = 9'd17;
    rst_n = 1'b1;
    for (int k = 0; k < 8 && !found; k++) begin
      @(negedge clk);
      if (!sram_oe_n) begin
        found = 1;
        chk(sram_addr == 10'd17, "R2 first slot is video", sram_addr, 17);
      end
    end
    chk(found, "R2 first read after reset", found, 1);
  endtask

  task automatic t_cpu_reads();
    logic [15:0] rd;
    int lat;
    for (int g = 0; g < 4; g++) begin
      repeat (g) @(negedge clk);
      cpu_access(1'b0, 10'(10'h200 + g * 9), 16'h0, rd, lat);
    end
    chk(seen1 && seen2, "R6 both latencies seen", {seen1, seen2}, 2'b11);
  endtask

  task automatic t_cpu_writes();
    logic [15:0] rd;
    int lat;
    cpu_access(1'b1, 10'h345, 16'hA5C3, rd, lat);
    cpu_access(1'b0, 10'h345, 16'h0, rd, lat);
    chk(rd == 16'hA5C3, "R5 upper write read back", rd, 16'hA5C3);
    cpu_access(1'b1, 10'h005, 16'hBEEF, rd, lat);
    vid_addr = 9'd5;
    @(negedge clk);
    t_vid_stream(6, 5, 0, "R5 video sees write", 1'b1, 1'b0);
  endtask

  task automatic t_cpu_under_video();
    fork
      t_vid_stream(30, 40, 7, "R7", 1'b1, 1'b0);
      begin
        logic [15:0] rd;
        int lat;
        cpu_access(1'b1, 10'h3A0, 16'h1234, rd, lat);
        cpu_access(1'b0, 10'h3A0, 16'h0, rd, lat);
        cpu_access(1'b1, 10'h2F1, 16'h7E01, rd, lat);
        cpu_access(1'b0, 10'h2F1, 16'h0, rd, lat);
      end
    join
  endtask

  task automatic t_blank_no_reclaim();
    @(negedge clk);
    vid_blank = 1'b1; reclaim_en = 1'b0;
    t_vid_stream(12, 100, 3, "R9", 1'b1, 1'b1);
  endtask

  task automatic t_reclaim();
    logic [15:0] rd;
    int lat;
    @(negedge clk);
    vid_blank = 1'b1; reclaim_en = 1'b1;
    @(negedge clk);
    t_vid_stream(8, 200, 1, "R8", 1'b0, 1'b0);
    for (int g = 0; g < 3; g++) begin
      repeat (g) @(negedge clk);
      cpu_access(1'b0, 10'(10'h280 + g), 16'h0, rd, lat);
      chk(lat == 1, "R8 reclaim latency", lat, 1);
    end
    reclaim_en = 1'b0; vid_blank = 1'b0;
    @(negedge clk);
    t_vid_stream(8, 300, 5, "R2 after reclaim", 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_vid_stream(16, 3, 5, "R2 R3", 1'b1, 1'b1);
    t_cpu_reads();
    t_cpu_writes();
    t_cpu_under_video();
    t_blank_no_reclaim();
    t_reclaim();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule